// File: doc/BRIEF.md
# Bridge control register file

This block is the word-addressed control register bank of a host bridge. It holds 28 slots of 32 bits: configuration, GPIO, interrupt-control, mailbox, cache and timing words. A CPU-side master reaches it through a single-cycle access port made of a strobe, a write flag, a byte address and write data. The slot index is the byte address shifted right by two. Only aligned word accesses are legal. Read data comes back combinationally in the same cycle, so reads have no wait states. The block never applies back-pressure: every strobed access completes in the cycle it is presented, so the port carries no ready signal.

Most slots are plain storage with fixed reset values. Four slots carry special behaviour. The interrupt enable word can only be changed through a set alias and a clear alias, and the enable word itself ignores direct writes. The status word is read-only. In the general configuration word, a 0-to-1 change of bit 2 produces a one-cycle system reset request. The interrupt edge-select, polarity and enable words are exported as vectors for the interrupt logic next to this block.

Top module: `bridge_regfile`

## Requirements
- R1: After reset, these offsets read back the following values: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008 and 0x6C=0x10000000. Every other slot reads zero, and soft_reset_req is low.
- R2: A write to a plain storage slot stores the full 32-bit word. A read presented in any later cycle returns that word on bus_rdata combinationally, in the same cycle as the strobe. The plain slots are every slot in 0x00..0x6C except 0x04, 0x30, 0x34, 0x38 and 0x3C.
- R3: A write to 0x30 (enable-set) stores the value in slot 0x30 and ORs it into the enable word at 0x38.
- R4: A write to 0x34 (enable-clear) stores the value in slot 0x34 and clears every bit of the enable word that is written as one.
- R5: Writes to 0x38 (enable) and 0x3C (status) leave both slots unchanged. The status slot always reads zero.
- R6: An access at an offset of 0x70 or above, or with address bits [1:0] not zero, changes no slot, and a read of it returns zero. bus_rdata is zero in any cycle that is not a strobed read.
- R7: A write to 0x04 whose bit 2 is 1 while the stored bit 2 is 0 stores the new value and raises soft_reset_req for exactly the one cycle after the write.
- R8: A write to 0x04 with bit 2 at 0, or with the stored bit 2 already 1, raises no reset request.
- R9: irq_edge_sel always equals the word at 0x24, irq_polarity the word at 0x2C, and irq_enable the word at 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the strobe |
| soft_reset_req | output | 1 | One-cycle system reset request |
| irq_edge_sel | output | 32 | Exported edge-select word |
| irq_polarity | output | 32 | Exported polarity word |
| irq_enable | output | 32 | Exported interrupt enable word |

## Verification
The bench targets the enable aliases. It interleaves sets and clears on overlapping bit patterns, so a design that copies the written value into the enable word instead of merging it, or that inverts the clear mask, reads back a wrong enable word. It writes the read-only and unmapped slots, and it makes misaligned accesses next to live slots. A decoder that drops the top address bits or ignores the low two bits would then corrupt a neighbour or return stale data. It walks bit 2 of the configuration word through clear, set, set again and set with other bits changing, so that level detection in place of edge detection shows up as extra or missing reset pulses.

// File: rtl/bridge_regs_pkg.sv
package bridge_regs_pkg;
  localparam int DATA_W      = 32;
  localparam int NUM_SLOTS   = 28;
  localparam int SLOT_GENCFG = 1;
  localparam int SLOT_EDGE   = 9;
  localparam int SLOT_POL    = 11;
  localparam int SLOT_EN_SET = 12;
  localparam int SLOT_EN_CLR = 13;
  localparam int SLOT_EN     = 14;
  localparam int SLOT_STATUS = 15;
  localparam int SOFTRST_BIT = 2;

  function automatic logic [DATA_W-1:0] slot_reset_value(input int idx);
    case (idx)
      0:       return 32'h0000_0C40;
      1:       return 32'h0000_1384;
      2:       return 32'h2BFF_8010;
      3:       return 32'h255E_0091;
      4:       return 32'h0000_6140;
      7:       return 32'h0000_01FF;
      8:       return 32'h0000_01FF;
      26:      return 32'h0000_0008;
      27:      return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/regfile_decode.sv
module regfile_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_SLOTS = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  output logic                 hit,
  output logic [ADDR_W-3:0]    slot_idx,
  output logic [NUM_SLOTS-1:0] slot_we
);
  localparam int IDX_W = ADDR_W - 2;

  assign slot_idx = bus_addr[ADDR_W-1:2];
  assign hit = bus_valid && (bus_addr[1:0] == 2'b00) &&
               (int'(slot_idx) < NUM_SLOTS);

  always_comb begin
    slot_we = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      slot_we[i] = hit && bus_write && (slot_idx == IDX_W'(i));
  end

  assert_we_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_we));
  assert_misaligned_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[1:0] != 2'b00) |-> (slot_we == '0));
endmodule

// File: rtl/regfile_store.sv
module regfile_store
  import bridge_regs_pkg::*;
#(
  parameter int NUM_SLOTS = 28
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_SLOTS-1:0]              slot_we,
  input  logic [DATA_W-1:0]                 wdata,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  words
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == SLOT_EN || i == SLOT_STATUS) begin : g_ro
      assign words[i] = '0;
    end else begin : g_rw
      localparam logic [DATA_W-1:0] RESET_VAL = slot_reset_value(i);
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          q <= RESET_VAL;
        else if (slot_we[i]) q <= wdata;
      end
      assign words[i] = q;

      assert_slot_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we[i] |=> (words[i] == $past(wdata)));
      assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_we[i] |=> $stable(words[i]));
    end
  end
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl
  import bridge_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic              direct_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] enable
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      enable <= '0;
    else if (set_we) enable <= enable | wdata;
    else if (clr_we) enable <= enable & ~wdata;
  end

  assert_set_merges_R3: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((enable & $past(wdata)) == $past(wdata)) &&
               ((enable & ~$past(wdata)) == ($past(enable) & ~$past(wdata))));
  assert_clr_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((enable & $past(wdata)) == '0) &&
               ((enable & ~$past(wdata)) == ($past(enable) & ~$past(wdata))));
  assert_direct_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    direct_we |=> $stable(enable));
endmodule

// File: rtl/soft_reset_detect.sv
module soft_reset_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic reset_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reset_req <= 1'b0;
    else        reset_req <= cfg_we && !old_bit && new_bit;
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> ($past(cfg_we) && $past(new_bit)));
  assert_no_pulse_when_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && old_bit) |=> !reset_req);
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile
  import bridge_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              soft_reset_req,
  output logic [31:0]       irq_edge_sel,
  output logic [31:0]       irq_polarity,
  output logic [31:0]       irq_enable
);
  localparam int IDX_W = ADDR_W - 2;

  logic                              hit;
  logic [IDX_W-1:0]                  slot_idx;
  logic [NUM_SLOTS-1:0]              slot_we;
  logic [NUM_SLOTS-1:0][DATA_W-1:0]  words;
  logic [DATA_W-1:0]                 enable_q;

  regfile_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_decode (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .hit(hit), .slot_idx(slot_idx), .slot_we(slot_we)
  );

  regfile_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .wdata(bus_wdata), .words(words)
  );

  irq_enable_ctl u_irq_en (
    .clk(clk), .rst_n(rst_n),
    .set_we(slot_we[SLOT_EN_SET]), .clr_we(slot_we[SLOT_EN_CLR]),
    .direct_we(slot_we[SLOT_EN]), .wdata(bus_wdata), .enable(enable_q)
  );

  soft_reset_detect u_softrst (
    .clk(clk), .rst_n(rst_n), .cfg_we(slot_we[SLOT_GENCFG]),
    .old_bit(words[SLOT_GENCFG][SOFTRST_BIT]),
    .new_bit(bus_wdata[SOFTRST_BIT]), .reset_req(soft_reset_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit && !bus_write) begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (slot_idx == IDX_W'(i))
          bus_rdata = (i == SLOT_EN) ? enable_q : words[i];
    end
  end

  assign irq_edge_sel = words[SLOT_EDGE];
  assign irq_polarity = words[SLOT_POL];
  assign irq_enable   = enable_q;

  assert_idle_rdata_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |-> (bus_rdata == '0));
  assert_status_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == ADDR_W'(SLOT_STATUS * 4)) |-> (bus_rdata == '0));
endmodule

// File: tb/bridge_regfile_tb.sv
module bridge_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        soft_reset_req;
  logic [31:0] irq_edge_sel, irq_polarity, irq_enable;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .soft_reset_req(soft_reset_req), .irq_edge_sel(irq_edge_sel),
    .irq_polarity(irq_polarity), .irq_enable(irq_enable)
  );

  function automatic logic [31:0] rst_val(input logic [7:0] a);
    case (a)
      8'h00: return 32'h00000C40;
      8'h04: return 32'h00001384;
      8'h08: return 32'h2BFF8010;
      8'h0C: return 32'h255E0091;
      8'h10: return 32'h00006140;
      8'h1C: return 32'h000001FF;
      8'h20: return 32'h000001FF;
      8'h68: return 32'h00000008;
      8'h6C: return 32'h10000000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops an expected item for each strobed read
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (bus_valid && !bus_write) begin
      if (sb_q.size() == 0) check(bus_rdata, 32'hx, "monitor underflow");
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(bus_rdata, e.exp, e.tag);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  // after wr returns: expected pulse level now, then low one cycle later
  task automatic pulse_check(input logic exp_now, input string tag);
    #(CLK_PERIOD/4);
    check({31'b0, soft_reset_req}, {31'b0, exp_now}, tag);
    @(negedge clk);
    #(CLK_PERIOD/4);
    check({31'b0, soft_reset_req}, 32'h0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] en_m;
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    check({31'b0, soft_reset_req}, 32'h0, "R1 reset pulse low");
    check(irq_enable, 32'h0, "R1 reset enable");
    rst_n = 1'b1;
    // R1: reset values of all slots
    for (int i = 0; i < 28; i++)
      rd(8'(i*4), rst_val(8'(i*4)), $sformatf("R1 reset slot %h", i*4));

    // R2: plain storage under several patterns
    wr(8'h08, 32'hDEADBEEF); wr(8'h40, 32'h12345678); wr(8'h4C, 32'hFFFFFFFF);
    wr(8'h6C, 32'h0); wr(8'h00, 32'hA5A5A5A5);
    rd(8'h08, 32'hDEADBEEF, "R2 slot 08");
    rd(8'h40, 32'h12345678, "R2 mailbox 40");
    rd(8'h4C, 32'hFFFFFFFF, "R2 mailbox 4C");
    rd(8'h6C, 32'h0, "R2 slot 6C");
    rd(8'h00, 32'hA5A5A5A5, "R2 slot 00");
    rd(8'h44, 32'h0, "R2 untouched mailbox 44");

    // R3/R4: set and clear aliases
    en_m = 32'h0;
    wr(8'h30, 32'h0000_00F0); en_m |= 32'h0000_00F0;
    rd(8'h38, en_m, "R3 enable after set");
    rd(8'h30, 32'h0000_00F0, "R3 set slot stores value");
    wr(8'h30, 32'h8000_0F0F); en_m |= 32'h8000_0F0F;
    rd(8'h38, en_m, "R3 enable after second set");
    wr(8'h34, 32'h0000_0330); en_m &= ~32'h0000_0330;
    rd(8'h38, en_m, "R4 enable after clear");
    rd(8'h34, 32'h0000_0330, "R4 clear slot stores value");
    wr(8'h34, 32'h0); 
    rd(8'h38, en_m, "R4 clear with zero keeps enable");
    check(irq_enable, en_m, "R9 irq_enable mirror");

    // R5: read-only enable and status
    wr(8'h38, 32'hFFFFFFFF);
    rd(8'h38, en_m, "R5 enable ignores direct write");
    wr(8'h3C, 32'h5555AAAA);
    rd(8'h3C, 32'h0, "R5 status ignores write");

    // R6: unmapped and misaligned
    wr(8'h70, 32'h11111111); wr(8'hFC, 32'h22222222);
    rd(8'h70, 32'h0, "R6 unmapped 70 reads zero");
    rd(8'hFC, 32'h0, "R6 unmapped FC reads zero");
    rd(8'h30, 32'h0000_0000 | 32'h8000_0F0F, "R6 slot 30 untouched by unmapped");
    wr(8'h41, 32'hCAFEF00D);
    rd(8'h40, 32'h12345678, "R6 misaligned write ignored");
    rd(8'h42, 32'h0, "R6 misaligned read zero");
    #(CLK_PERIOD/4);
    check(bus_rdata, 32'h0, "R6 idle rdata zero");

    // R7/R8: soft reset edge detection (reset value has bit 2 set)
    wr(8'h04, 32'h0000_1384); pulse_check(1'b0, "R8 bit already set");
    wr(8'h04, 32'h0000_1380); pulse_check(1'b0, "R8 bit cleared");
    wr(8'h04, 32'h0000_0004); pulse_check(1'b1, "R7 rising bit pulse");
    rd(8'h04, 32'h0000_0004, "R7 value stored");
    wr(8'h04, 32'hFFFF_FFFF); pulse_check(1'b0, "R8 bit stays set");
    wr(8'h04, 32'h0000_0000); pulse_check(1'b0, "R8 write zero");
    wr(8'h04, 32'h0000_0004); pulse_check(1'b1, "R7 second rise");

    // R9: exported vectors
    wr(8'h24, 32'h0F0F_1234); wr(8'h2C, 32'hF000_000F); wr(8'h28, 32'h7777_7777);
    #(CLK_PERIOD/4);
    check(irq_edge_sel, 32'h0F0F_1234, "R9 edge vector");
    check(irq_polarity, 32'hF000_000F, "R9 polarity vector");
    check(irq_enable, en_m, "R9 enable vector");
    rd(8'h28, 32'h7777_7777, "R2 steering slot");

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) check(32'(sb_q.size()), 32'h0, "scoreboard drained");
    finish_run();
  end
endmodule